// File: doc/BRIEF.md
# Boot Image Stream Parser

This block sits between a generic source of boot data and a memory write port. The source hands over one 16-bit word per transfer under valid/ready flow control. The parser reads a leading key from the source. The key tells it whether the image arrives as full 16-bit words or as single bytes. In byte mode each byte occupies the low eight bits of a source word.

Once the key is accepted, the parser drops a fixed number of header words. It then captures a 32-bit jump address. After that it walks a chain of code blocks. Each block carries a word count, a 32-bit target address and then its payload. Every payload word becomes one write on the memory port, at consecutive addresses. A zero count closes the image, and the parser then holds `done` with the captured jump address. An unknown key makes the parser stop at once and hold `error` with a fixed fallback jump address.

Top module: `boot_stream_parser`

## Requirements
- R1: A first source word equal to 0x10AA selects word mode, in which each accepted source word is one 16-bit image word.
- R2: Byte mode is selected when the low byte of the first source word is 0xAA and the low byte of the second is 0x08, so the pair forms 0x08AA with the low byte first. In byte mode, bits 15:8 of every source word are ignored.
- R3: In byte mode each image word is built from two transfers, the first giving bits 7:0 and the second giving bits 15:8.
- R4: A key that matches neither value sets `error` to 1 and `entry_addr` to 0x003F7FF6. No memory write is made, and `src_ready` stays low until reset.
- R5: After the key, exactly RSVD_WORDS image words (default 8) are consumed and discarded, whatever their values, and no write results from them.
- R6: The next two image words form the jump address, high half first. That address appears on `entry_addr` while `done` is 1.
- R7: A block consists of a nonzero count N, a target address (high half first) and N payload words. Payload word k is written to address target+k. `wr_en` is high for one cycle per word, in the cycle after that word's last source transfer is accepted.
- R8: A block count of zero sets `done` to 1. No further write follows, and `src_ready` stays low until reset.
- R9: Any number of blocks may follow one another, each starting from its own target address.
- R10: A transfer takes place only in a cycle where `src_valid` and `src_ready` are both high. Idle cycles inserted by the source change neither the writes nor the result.
- R11: While `rst_n` is low on a clock edge, the parser returns to waiting for the key. After that edge `done`, `error` and `wr_en` are 0 and `src_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| src_valid | input | 1 | Source holds a word |
| src_ready | output | 1 | Parser takes the word this cycle |
| src_data | input | 16 | Source word; only bits 7:0 are used in byte mode |
| wr_en | output | 1 | Memory write strobe |
| wr_addr | output | 32 | Memory write address |
| wr_data | output | 16 | Memory write data |
| done | output | 1 | Image fully parsed |
| error | output | 1 | Key rejected |
| entry_addr | output | 32 | Jump address, meaningful while done or error is 1 |

## Verification
The parser is exercised with a word-mode image of two blocks of different lengths. It is also given a byte-mode image in which the ignored upper source bits carry junk and the source pauses between transfers, so a parser that used those bits or counted idle cycles would write the wrong data. Reserved header words are filled with values that look like keys or counts, which exposes any parser that reads them. Two bad keys are used: one that fails on the first word and one that passes the first byte but fails on the second. Together they separate the early and late rejection paths, and a reset in the middle of a load shows that no leftover state carries into the next image.

// File: rtl/boot_parse_pkg.sv
// Shared constants and state type for the boot image stream parser.
// Assumes a 16-bit image word and 32-bit addresses, as fixed by the format.
package boot_parse_pkg;
    localparam int WORD_W = 16;
    localparam int ADDR_W = 32;
    localparam logic [WORD_W-1:0] KEY_WIDE   = 16'h10AA;
    localparam logic [WORD_W-1:0] KEY_NARROW = 16'h08AA;
    localparam logic [ADDR_W-1:0] FALLBACK_ENTRY = 32'h003F_7FF6;

    typedef enum logic [3:0] {
        P_KEY,      // first key transfer
        P_KEY_HI,   // second byte of a narrow key
        P_RSVD,     // discarding header words
        P_ENT_HI,
        P_ENT_LO,
        P_BLK_SIZE,
        P_BLK_AHI,
        P_BLK_ALO,
        P_DATA,
        P_DONE,
        P_ERR
    } pstate_t;
endpackage

// File: rtl/word_assembler.sv
// Turns source transfers into 16-bit image words once the width is known.
// Word mode passes each transfer through. Byte mode keeps the first
// transfer's low byte and joins it with the low byte of the next one.
// Assumes the consumer's ready does not depend on word_valid.
module word_assembler
    import boot_parse_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              byte_mode,
    input  logic              src_valid,
    output logic              src_ready,
    input  logic [WORD_W-1:0] src_data,
    output logic              word_valid,
    input  logic              word_ready,
    output logic [WORD_W-1:0] word_data
);
    localparam int BYTE_W = WORD_W / 2;

    logic              have_lo;
    logic [BYTE_W-1:0] lo_q;

    // Handshake and data path for both widths
    always_comb begin
        if (!byte_mode) begin
            word_valid = enable & src_valid;
            word_data  = src_data;
            src_ready  = enable & word_ready;
        end else if (!have_lo) begin
            word_valid = 1'b0;
            word_data  = src_data;
            src_ready  = enable;
        end else begin
            word_valid = enable & src_valid;
            word_data  = {src_data[BYTE_W-1:0], lo_q};
            src_ready  = enable & word_ready;
        end
    end

    // Holds the pending low byte between the two halves of a word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            have_lo <= 1'b0;
            lo_q    <= '0;
        end else if (byte_mode && src_valid && src_ready) begin
            have_lo <= ~have_lo;
            if (!have_lo) lo_q <= src_data[BYTE_W-1:0];
        end
    end

    a_r3_word_mode_no_pend: assert property (@(posedge clk) disable iff (!rst_n)
        !byte_mode |-> !have_lo);
endmodule

// File: rtl/parse_ctrl.sv
// Sequencer for the boot image: key check, header skip, jump address
// capture and the block walk that issues memory writes.
// Assumes words arrive through word_valid/word_ready once past the key.
module parse_ctrl
    import boot_parse_pkg::*;
#(
    parameter int RSVD_WORDS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              src_valid,
    input  logic [WORD_W-1:0] src_data,
    output logic              key_ready,
    input  logic              word_valid,
    input  logic [WORD_W-1:0] word_data,
    output logic              consume,
    output logic              byte_mode,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [WORD_W-1:0] wr_data,
    output logic              done,
    output logic              error,
    output logic [ADDR_W-1:0] entry_addr
);
    localparam int CNT_W = $clog2(RSVD_WORDS + 1);
    localparam logic [CNT_W-1:0] RSVD_LAST = CNT_W'(RSVD_WORDS - 1);

    pstate_t           state;
    logic [CNT_W-1:0]  rsvd_cnt;
    logic [WORD_W-1:0] hold_hi;
    logic [WORD_W-1:0] remain;
    logic [ADDR_W-1:0] cur_addr;
    logic              key_fire;
    logic              wfire;

    // Which side of the stream is being read this cycle
    always_comb begin
        key_ready = (state == P_KEY) || (state == P_KEY_HI);
        consume   = (state == P_RSVD) || (state == P_ENT_HI) || (state == P_ENT_LO) ||
                    (state == P_BLK_SIZE) || (state == P_BLK_AHI) ||
                    (state == P_BLK_ALO) || (state == P_DATA);
        key_fire  = key_ready & src_valid;
        wfire     = consume & word_valid;
        done      = (state == P_DONE);
        error     = (state == P_ERR);
    end

    // Stream sequencer and write issue
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= P_KEY;
            byte_mode  <= 1'b0;
            rsvd_cnt   <= '0;
            hold_hi    <= '0;
            remain     <= '0;
            cur_addr   <= '0;
            wr_en      <= 1'b0;
            wr_addr    <= '0;
            wr_data    <= '0;
            entry_addr <= '0;
        end else begin
            wr_en <= 1'b0;
            if (key_fire) begin
                if (state == P_KEY) begin
                    if (src_data == KEY_WIDE) begin
                        byte_mode <= 1'b0;
                        state     <= P_RSVD;
                    end else if (src_data[7:0] == KEY_NARROW[7:0]) begin
                        state <= P_KEY_HI;
                    end else begin
                        state      <= P_ERR;
                        entry_addr <= FALLBACK_ENTRY;
                    end
                end else if (src_data[7:0] == KEY_NARROW[15:8]) begin
                    byte_mode <= 1'b1;
                    state     <= P_RSVD;
                end else begin
                    state      <= P_ERR;
                    entry_addr <= FALLBACK_ENTRY;
                end
            end else if (wfire) begin
                case (state)
                    P_RSVD: begin
                        rsvd_cnt <= rsvd_cnt + 1'b1;
                        if (rsvd_cnt == RSVD_LAST) begin
                            rsvd_cnt <= '0;
                            state    <= P_ENT_HI;
                        end
                    end
                    P_ENT_HI: begin
                        hold_hi <= word_data;
                        state   <= P_ENT_LO;
                    end
                    P_ENT_LO: begin
                        entry_addr <= {hold_hi, word_data};
                        state      <= P_BLK_SIZE;
                    end
                    P_BLK_SIZE: begin
                        remain <= word_data;
                        state  <= (word_data == '0) ? P_DONE : P_BLK_AHI;
                    end
                    P_BLK_AHI: begin
                        hold_hi <= word_data;
                        state   <= P_BLK_ALO;
                    end
                    P_BLK_ALO: begin
                        cur_addr <= {hold_hi, word_data};
                        state    <= P_DATA;
                    end
                    P_DATA: begin
                        wr_en    <= 1'b1;
                        wr_addr  <= cur_addr;
                        wr_data  <= word_data;
                        cur_addr <= cur_addr + 1'b1;
                        remain   <= remain - 1'b1;
                        if (remain == 16'd1) state <= P_BLK_SIZE;
                    end
                    default: state <= state;
                endcase
            end
        end
    end

    a_r7_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && $past(wr_en)) |-> (wr_addr == $past(wr_addr) + 1'b1));
    a_r4_fallback_entry: assert property (@(posedge clk) disable iff (!rst_n)
        error |-> (entry_addr == FALLBACK_ENTRY && !wr_en));
    a_r8_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!wr_en && !consume));
    a_r1_wide_key_mode: assert property (@(posedge clk) disable iff (!rst_n)
        (state == P_RSVD && $past(state) == P_KEY) |-> !byte_mode);
endmodule

// File: rtl/boot_stream_parser.sv
// Top of the boot image stream parser. The controller reads the key
// straight from the source. After that the assembler feeds it whole words.
// Assumes a source that keeps data stable while valid is high and not ready.
module boot_stream_parser
    import boot_parse_pkg::*;
#(
    parameter int RSVD_WORDS = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        src_valid,
    output logic        src_ready,
    input  logic [15:0] src_data,
    output logic        wr_en,
    output logic [31:0] wr_addr,
    output logic [15:0] wr_data,
    output logic        done,
    output logic        error,
    output logic [31:0] entry_addr
);
    logic              key_ready;
    logic              asm_ready;
    logic              consume;
    logic              byte_mode;
    logic              word_valid;
    logic [WORD_W-1:0] word_data;

    word_assembler u_asm (
        .clk(clk), .rst_n(rst_n), .enable(consume), .byte_mode(byte_mode),
        .src_valid(src_valid), .src_ready(asm_ready), .src_data(src_data),
        .word_valid(word_valid), .word_ready(consume), .word_data(word_data)
    );

    parse_ctrl #(.RSVD_WORDS(RSVD_WORDS)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .src_valid(src_valid), .src_data(src_data),
        .key_ready(key_ready), .word_valid(word_valid), .word_data(word_data),
        .consume(consume), .byte_mode(byte_mode), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .done(done), .error(error),
        .entry_addr(entry_addr)
    );

    // Source ready comes from whichever stage owns the stream
    always_comb src_ready = key_ready | asm_ready;

    a_r11_end_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && error));
    a_r8_stream_closed: assert property (@(posedge clk) disable iff (!rst_n)
        (done || error) |-> !src_ready);
endmodule

// File: tb/sim_boot_stream_parser.sv
module sim_boot_stream_parser;
    localparam int PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        src_valid = 1'b0;
    logic [15:0] src_data = '0;
    logic        src_ready, wr_en, done, error;
    logic [31:0] wr_addr, entry_addr;
    logic [15:0] wr_data;

    int checks = 0;
    int errors = 0;
    bit byte_src = 1'b0;
    int n_wr = 0;
    logic [31:0] log_addr [0:63];
    logic [15:0] log_data [0:63];

    boot_stream_parser u0 (
        .clk(clk), .rst_n(rst_n), .src_valid(src_valid), .src_ready(src_ready),
        .src_data(src_data), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .done(done), .error(error), .entry_addr(entry_addr)
    );

    always #(PERIOD/2) clk = ~clk;

    // Write monitor, sampled away from the active edge
    always @(negedge clk) begin
        if (rst_n && wr_en && n_wr < 64) begin
            log_addr[n_wr] = wr_addr;
            log_data[n_wr] = wr_data;
            n_wr++;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic push(input logic [15:0] w, input int gap);
        if (gap > 0) begin
            @(negedge clk);
            src_valid = 1'b0;
            repeat (gap - 1) @(negedge clk);
        end
        @(negedge clk);
        src_valid = 1'b1;
        src_data  = w;
        while (!src_ready) @(negedge clk);
        @(posedge clk);
    endtask

    // One image word, split in byte mode with junk in the upper source bits
    task automatic put(input logic [15:0] w, input int gap);
        if (byte_src) begin
            push({8'hC3, w[7:0]}, gap);
            push({8'h5E, w[15:8]}, gap);
        end else begin
            push(w, gap);
        end
    endtask

    task automatic idle();
        @(negedge clk);
        src_valid = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        src_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        n_wr = 0;
        chk("R11 done", {31'd0, done}, 32'd0);
        chk("R11 error", {31'd0, error}, 32'd0);
        chk("R11 wr_en", {31'd0, wr_en}, 32'd0);
        chk("R11 src_ready", {31'd0, src_ready}, 32'd1);
    endtask

    task automatic header(input logic [31:0] entry, input int gap);
        // reserved words look like keys and counts on purpose (R5)
        for (int i = 0; i < 8; i++) put((i % 2) ? 16'h10AA : 16'h0000, gap);
        put(entry[31:16], gap);
        put(entry[15:0], gap);
    endtask

    task automatic t_word_two_blocks();
        do_reset();
        byte_src = 1'b0;
        push(16'h10AA, 0);                // R1
        header(32'h003F_8000, 0);
        put(16'd3, 0); put(16'h0000, 0); put(16'h0100, 0);
        put(16'hA1A1, 0); put(16'hA2A2, 0); put(16'hA3A3, 0);
        put(16'd1, 0); put(16'h0012, 0); put(16'h3456, 0);
        put(16'h7777, 0);
        put(16'd0, 0);                    // R8
        idle();
        chk("R5 R7 write count", n_wr, 4);
        chk("R7 addr0", log_addr[0], 32'h0000_0100);
        chk("R7 addr2", log_addr[2], 32'h0000_0102);
        chk("R1 data1", {16'd0, log_data[1]}, 32'h0000_A2A2);
        chk("R9 second block addr", log_addr[3], 32'h0012_3456);
        chk("R9 second block data", {16'd0, log_data[3]}, 32'h0000_7777);
        chk("R8 done", {31'd0, done}, 32'd1);
        chk("R6 entry", entry_addr, 32'h003F_8000);
        chk("R8 src_ready closed", {31'd0, src_ready}, 32'd0);
        chk("R8 error clear", {31'd0, error}, 32'd0);
    endtask

    task automatic t_byte_gaps();
        do_reset();
        byte_src = 1'b0;
        push(16'h77AA, 2);                // R2 key low byte, junk upper
        push(16'hE608, 1);                // R2 key high byte
        byte_src = 1'b1;
        header(32'h0012_3456, 2);         // R10 idle cycles
        put(16'd2, 1); put(16'h0000, 0); put(16'h0200, 3);
        put(16'hBEEF, 2); put(16'h1234, 0);
        put(16'd0, 1);
        idle();
        chk("R10 write count", n_wr, 2);
        chk("R3 data0", {16'd0, log_data[0]}, 32'h0000_BEEF);
        chk("R3 data1", {16'd0, log_data[1]}, 32'h0000_1234);
        chk("R7 byte addr1", log_addr[1], 32'h0000_0201);
        chk("R2 done", {31'd0, done}, 32'd1);
        chk("R6 byte entry", entry_addr, 32'h0012_3456);
    endtask

    task automatic t_bad_first();
        do_reset();
        push(16'h1234, 0);
        idle();
        chk("R4 error", {31'd0, error}, 32'd1);
        chk("R4 fallback", entry_addr, 32'h003F_7FF6);
        chk("R4 src_ready", {31'd0, src_ready}, 32'd0);
        chk("R4 done clear", {31'd0, done}, 32'd0);
    endtask

    task automatic t_bad_second();
        do_reset();
        push(16'h00AA, 0);
        push(16'h0009, 0);
        idle();
        chk("R4 late error", {31'd0, error}, 32'd1);
        chk("R4 late fallback", entry_addr, 32'h003F_7FF6);
        chk("R4 no writes", n_wr, 0);
    endtask

    task automatic t_mid_reset();
        do_reset();
        byte_src = 1'b0;
        push(16'h10AA, 0);
        put(16'h1111, 0); put(16'h2222, 0);
        do_reset();                       // R11 checked inside
        byte_src = 1'b0;
        push(16'h10AA, 0);
        header(32'hCAFE_0001, 0);
        put(16'd1, 0); put(16'h0000, 0); put(16'h0040, 0); put(16'h5A5A, 0);
        put(16'd0, 0);
        idle();
        chk("R11 fresh load writes", n_wr, 1);
        chk("R11 fresh load addr", log_addr[0], 32'h0000_0040);
        chk("R11 fresh entry", entry_addr, 32'hCAFE_0001);
    endtask

    initial begin
        t_word_two_blocks();
        t_byte_gaps();
        t_bad_first();
        t_bad_second();
        t_mid_reset();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(PERIOD * 100000);
        errors++;
        checks++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule